// File: doc/BRIEF.md
# SD Host Command Issue Register

This block is the 16-bit command register of an SD/SDIO host controller together with the logic that launches a command when software writes it. Software writes the register through byte-lane strobes. A write that touches the upper byte captures the command index and the other fields and starts a 48-bit command frame. The frame is shifted out on the CMD line, one bit for each SD clock enable. The 32-bit argument is taken from an input port at the moment of launch.

While a frame is on the line, the block holds a CMD inhibit flag. A DAT inhibit flag is held for commands that carry data. The command-type field drives level outputs towards the data path. An abort tells an active read to stop filling the buffer, or an active write to stop driving DAT. A successful suspend releases the bus: read-wait is deasserted, write busy checking stops and a new DAT command is allowed. A resume asks the data path to check DAT[0] busy before it starts a write. Response reception, the data engine and DMA sit outside this block. Its outputs and its suspend-result input connect to them.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, rd_data reads 0000h, cmd_line is 1, and inhibit_cmd, inhibit_dat, stop_buf_read, stop_dat_drive, bus_released and resume_busy_chk are 0. Bits 15:14 of rd_data always read 0, whatever is written.
- R2: A write whose byte strobe wr_be is 2'b01 updates only bits 7:0 and starts no frame. cmd_line stays 1 and inhibit_cmd stays 0.
- R3: A write with wr_be[1]=1 stores bits 13:8 as the command index and starts a frame in the next cycle. inhibit_cmd goes to 1 and cmd_line carries, MSB first, these 48 bits: a start bit 0, a transmission bit 1, the 6-bit index, the 32-bit cmd_arg sampled at the write, the CRC7, and an end bit 1. Each bit is held until a cycle with sd_clk_en=1 advances it.
- R4: The CRC7 is computed with polynomial x^7+x^3+1 and a zero initial value over the first 40 frame bits.
- R5: After the sd_clk_en cycle that ends the end bit, cmd_done pulses for exactly one cycle, inhibit_cmd returns to 0 and cmd_line returns to 1.
- R6: A launching write while inhibit_cmd is 1 is accepted. The frame in progress is dropped without a cmd_done, and the new frame starts from its start bit.
- R7: A launch with data-present bit 5 = 1 sets inhibit_dat. The bit is cleared by a dat_done pulse. data_present mirrors stored bit 5.
- R8: Command type is bits 7:6, where 00 is normal, 01 suspend, 10 resume and 11 abort. An abort launch sets stop_buf_read if rd_active is 1 and stop_dat_drive if wr_active is 1. Both are held until the next launch.
- R9: After a suspend launch, a susp_valid pulse with susp_ok=1 sets bus_released and clears inhibit_dat. With susp_ok=0, inhibit_dat and bus_released keep their values. bus_released clears at the next launch.
- R10: A resume launch sets resume_busy_chk, and any other launch clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sd_clk_en | input | 1 | One-cycle enable per SD clock bit period |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte-lane enables (bit 1 = upper byte, launches) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register read value |
| cmd_arg | input | 32 | Command argument, sampled at launch |
| rd_active | input | 1 | A read data transfer is in progress |
| wr_active | input | 1 | A write data transfer is in progress |
| susp_valid | input | 1 | Suspend command result is available |
| susp_ok | input | 1 | Suspend succeeded (qualified by susp_valid) |
| dat_done | input | 1 | Data transfer finished, releases DAT inhibit |
| cmd_line | output | 1 | Serial CMD line, high when idle |
| cmd_done | output | 1 | One-cycle pulse after the end bit |
| inhibit_cmd | output | 1 | CMD inhibit flag |
| inhibit_dat | output | 1 | DAT inhibit flag |
| data_present | output | 1 | Current command uses DAT for data |
| stop_buf_read | output | 1 | Abort: stop filling the read buffer |
| stop_dat_drive | output | 1 | Abort: stop driving DAT for writes |
| bus_released | output | 1 | Suspend succeeded: read-wait off, write busy check off |
| resume_busy_chk | output | 1 | Resume: check DAT[0] busy before a write |

## Verification
The hardest case to reach is a launch that lands in the middle of a frame. The dropped frame must leave no trace: no cmd_done, and the new frame must start from its own start bit and not resume the old shift position. The stimulus stops the first frame after a random number of bits, writes a new command and then collects all 48 bits of the second frame. A second hard case is the suspend handshake with a failing result. The bench first holds DAT inhibit with a data command, issues a suspend and returns a failed result, then checks that nothing moved before it repeats the suspend with a good result.

// File: rtl/sdc_pkg.sv
// Package: shared constants, command-type encoding and the CRC7 function
// for the SD command issue block. Assumes MSB-first CRC over frame bits.
package sdc_pkg;

    localparam int FRAME_W = 48;
    localparam int IDX_W   = 6;
    localparam int ARG_W   = 32;
    localparam int CRC_W   = 7;
    localparam int BODY_W  = 2 + IDX_W + ARG_W;

    typedef enum logic [1:0] {
        CT_NORMAL  = 2'b00,
        CT_SUSPEND = 2'b01,
        CT_RESUME  = 2'b10,
        CT_ABORT   = 2'b11
    } cmd_kind_e;

    // CRC7, polynomial x^7 + x^3 + 1, zero seed, data taken MSB first
    function automatic logic [CRC_W-1:0] crc7_calc(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] crc;
        logic             fb;
        crc = '0;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            fb  = body[i] ^ crc[CRC_W-1];
            crc = {crc[CRC_W-2:0], 1'b0};
            if (fb) crc = crc ^ 7'h09;
        end
        return crc;
    endfunction

endpackage

// File: rtl/sdc_cmd_reg.sv
// Module: command register storage with byte-lane writes.
// Holds bits 13:0; bits 15:14 are reserved and held at zero.
// Assumes wr_en is a single-cycle strobe; an upper-lane write is a launch.
module sdc_cmd_reg #(
    parameter int REG_W = 16,
    parameter int RSVD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_be,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] reg_q,
    output logic [REG_W-1:0] reg_nxt,
    output logic             launch
);
    localparam int HALF = REG_W / 2;

    // Merge the written lanes with the stored value
    always_comb begin
        reg_nxt = reg_q;
        if (wr_be[0]) reg_nxt[HALF-1:0] = wr_data[HALF-1:0];
        if (wr_be[1]) reg_nxt[REG_W-1:HALF] = {{RSVD_W{1'b0}}, wr_data[REG_W-RSVD_W-1:HALF]};
    end

    // Upper-lane write is the launch strobe
    assign launch = wr_en & wr_be[1];

    // Register storage
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_q <= '0;
        else if (wr_en) reg_q <= reg_nxt;
    end

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q[REG_W-1:REG_W-RSVD_W] == '0);

    assert_low_write_keeps_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 2'b01) |=> $stable(reg_q[REG_W-1:HALF]));

endmodule

// File: rtl/sdc_frame_tx.sv
// Module: builds the 48-bit command frame and shifts it out MSB first,
// one bit per bit_en. A load always restarts from the start bit.
// Assumes load and bit_en are synchronous to clk.
module sdc_frame_tx
    import sdc_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int IW = IDX_W,
    parameter int AW = ARG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] index,
    input  logic [AW-1:0] arg,
    input  logic          bit_en,
    output logic          line,
    output logic          busy,
    output logic          done
);
    localparam int CNT_W = $clog2(FW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FW - 1);

    logic [FW-1:0]    frame;
    logic [FW-1:0]    shreg;
    logic [CNT_W-1:0] cnt;
    logic [CRC_W-1:0] crc;

    // Frame assembly: start, transmission, index, argument, CRC7, end
    always_comb begin
        crc   = crc7_calc({2'b01, index, arg});
        frame = {2'b01, index, arg, crc, 1'b1};
    end

    // Shift engine and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                shreg <= frame;
                cnt   <= '0;
                busy  <= 1'b1;
            end else if (busy && bit_en) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    shreg <= {shreg[FW-2:0], 1'b1};
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end

    // Line is high while idle
    assign line = busy ? shreg[FW-1] : 1'b1;

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);

    assert_load_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && !line));

    assert_hold_without_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_en && !load) |=> $stable(line));

    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/sdc_side_ctl.sv
// Module: command-inhibit for DAT and the data-path side effects of the
// command type (abort, suspend, resume). Side-effect levels are held
// until the next launch. Assumes susp_valid comes from the response logic.
module sdc_side_ctl
    import sdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      launch,
    input  cmd_kind_e kind,
    input  logic      data_pres,
    input  logic      rd_active,
    input  logic      wr_active,
    input  logic      susp_valid,
    input  logic      susp_ok,
    input  logic      dat_done,
    output logic      dat_inhibit,
    output logic      stop_rd,
    output logic      stop_wr,
    output logic      bus_rel,
    output logic      resume_chk
);
    logic susp_pend;
    logic susp_win;

    assign susp_win = susp_pend & susp_valid & susp_ok;

    // DAT inhibit: set by a data launch, released by data end or suspend
    always_ff @(posedge clk) begin
        if (!rst_n)                   dat_inhibit <= 1'b0;
        else if (launch && data_pres) dat_inhibit <= 1'b1;
        else if (dat_done || susp_win) dat_inhibit <= 1'b0;
    end

    // Abort and resume levels, recomputed at every launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_rd    <= 1'b0;
            stop_wr    <= 1'b0;
            resume_chk <= 1'b0;
        end else if (launch) begin
            stop_rd    <= (kind == CT_ABORT) && rd_active;
            stop_wr    <= (kind == CT_ABORT) && wr_active;
            resume_chk <= (kind == CT_RESUME);
        end
    end

    // Suspend result tracking and bus release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_pend <= 1'b0;
            bus_rel   <= 1'b0;
        end else if (launch) begin
            susp_pend <= (kind == CT_SUSPEND);
            bus_rel   <= 1'b0;
        end else if (susp_pend && susp_valid) begin
            susp_pend <= 1'b0;
            if (susp_ok) bus_rel <= 1'b1;
        end
    end

    assert_data_launch_inhibits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && data_pres) |=> dat_inhibit);

    assert_abort_read_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && kind == CT_ABORT && rd_active) |=> stop_rd);

    assert_suspend_fail_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_valid && !susp_ok && !launch && !dat_done) |=> ($stable(dat_inhibit) && $stable(bus_rel)));

    assert_suspend_ok_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_pend && susp_valid && susp_ok && !launch) |=> (bus_rel && !dat_inhibit));

    assert_resume_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (resume_chk == ($past(kind) == CT_RESUME)));

endmodule

// File: rtl/sd_cmd_issue.sv
// Module: top of the SD command issue block. Connects the command register,
// the frame shifter and the data-path side-effect control. Assumes a single
// clock domain and that sd_clk_en marks SD bit periods.
module sd_cmd_issue
    import sdc_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_clk_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_be,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic             rd_active,
    input  logic             wr_active,
    input  logic             susp_valid,
    input  logic             susp_ok,
    input  logic             dat_done,
    output logic             cmd_line,
    output logic             cmd_done,
    output logic             inhibit_cmd,
    output logic             inhibit_dat,
    output logic             data_present,
    output logic             stop_buf_read,
    output logic             stop_dat_drive,
    output logic             bus_released,
    output logic             resume_busy_chk
);
    localparam int HALF   = REG_W / 2;
    localparam int DP_BIT = 5;

    logic [REG_W-1:0] reg_q;
    logic [REG_W-1:0] reg_nxt;
    logic             launch;
    cmd_kind_e        kind_nxt;

    sdc_cmd_reg #(.REG_W(REG_W), .RSVD_W(2)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .reg_q   (reg_q),
        .reg_nxt (reg_nxt),
        .launch  (launch)
    );

    assign kind_nxt = cmd_kind_e'(reg_nxt[7:6]);

    sdc_frame_tx #(.FW(FRAME_W), .IW(IDX_W), .AW(ARG_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (launch),
        .index  (reg_nxt[HALF+IDX_W-1:HALF]),
        .arg    (cmd_arg),
        .bit_en (sd_clk_en),
        .line   (cmd_line),
        .busy   (inhibit_cmd),
        .done   (cmd_done)
    );

    sdc_side_ctl u_side (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .kind        (kind_nxt),
        .data_pres   (reg_nxt[DP_BIT]),
        .rd_active   (rd_active),
        .wr_active   (wr_active),
        .susp_valid  (susp_valid),
        .susp_ok     (susp_ok),
        .dat_done    (dat_done),
        .dat_inhibit (inhibit_dat),
        .stop_rd     (stop_buf_read),
        .stop_wr     (stop_dat_drive),
        .bus_rel     (bus_released),
        .resume_chk  (resume_busy_chk)
    );

    // Register read-back and data-present mirror
    assign rd_data      = reg_q;
    assign data_present = reg_q[DP_BIT];

    assert_launch_sets_cmd_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> inhibit_cmd);

    assert_low_write_no_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 2'b01 && !inhibit_cmd) |=> !inhibit_cmd);

endmodule

// File: tb/sd_cmd_issue_bench.sv
// Bench: directed corner cases plus seeded random commands, frames checked
// against a model built from the requirements.
module sd_cmd_issue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_clk_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [31:0] cmd_arg = '0;
    logic        rd_active = 1'b0;
    logic        wr_active = 1'b0;
    logic        susp_valid = 1'b0;
    logic        susp_ok = 1'b0;
    logic        dat_done = 1'b0;
    logic        cmd_line, cmd_done, inhibit_cmd, inhibit_dat, data_present;
    logic        stop_buf_read, stop_dat_drive, bus_released, resume_busy_chk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sd_cmd_issue u_sd_cmd_issue (
        .clk(clk), .rst_n(rst_n), .sd_clk_en(sd_clk_en), .wr_en(wr_en),
        .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data), .cmd_arg(cmd_arg),
        .rd_active(rd_active), .wr_active(wr_active), .susp_valid(susp_valid),
        .susp_ok(susp_ok), .dat_done(dat_done), .cmd_line(cmd_line),
        .cmd_done(cmd_done), .inhibit_cmd(inhibit_cmd), .inhibit_dat(inhibit_dat),
        .data_present(data_present), .stop_buf_read(stop_buf_read),
        .stop_dat_drive(stop_dat_drive), .bus_released(bus_released),
        .resume_busy_chk(resume_busy_chk)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] model_crc(input logic [39:0] b);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic f = b[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (f) c[3] = ~c[3];
            c[0] = f;
        end
        return c;
    endfunction

    function automatic logic [47:0] model_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, model_crc({2'b01, idx, arg}), 1'b1};
    endfunction

    // Register write; starts and ends at a falling edge
    task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic [31:0] a);
        wr_en = 1'b1; wr_be = be; wr_data = d; cmd_arg = a;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    // Collect n bits of the frame with random gaps between enables
    task automatic shift_bits(input int n, input int maxgap, output logic [47:0] f);
        f = '0;
        for (int i = 0; i < n; i++) begin
            int gap = (maxgap > 0) ? int'($urandom_range(maxgap)) : 0;
            repeat (gap) @(negedge clk);
            f = {f[46:0], cmd_line};
            sd_clk_en = 1'b1;
            @(negedge clk);
            sd_clk_en = 1'b0;
        end
    endtask

    task automatic full_frame(input logic [5:0] idx, input logic [31:0] arg, input int maxgap, input string tag);
        logic [47:0] f;
        shift_bits(48, maxgap, f);
        chk(f == model_frame(idx, arg), tag, {16'h0, f}, {16'h0, model_frame(idx, arg)});
        chk(cmd_done == 1'b1 && inhibit_cmd == 1'b0, "R5 done pulse and inhibit clear",
            {cmd_done, inhibit_cmd}, 2'b10);
        @(negedge clk);
        chk(cmd_done == 1'b0 && cmd_line == 1'b1, "R5 single pulse, line idle high",
            {cmd_done, cmd_line}, 2'b01);
    endtask

    task automatic pulse_dat_done();
        dat_done = 1'b1; @(negedge clk); dat_done = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5D1C_0A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(rd_data == 16'h0000, "R1 reset rd_data", rd_data, 0);
        chk(cmd_line && !inhibit_cmd && !inhibit_dat, "R1 reset line and inhibits",
            {cmd_line, inhibit_cmd, inhibit_dat}, 3'b100);
        chk({stop_buf_read, stop_dat_drive, bus_released, resume_busy_chk} == 4'b0,
            "R1 reset side outputs", {stop_buf_read, stop_dat_drive, bus_released, resume_busy_chk}, 0);

        // R2 lower byte only: no launch
        wr(2'b01, 16'hFFA5, 32'h0);
        chk(rd_data == 16'h00A5, "R2 lower byte stored", rd_data, 16'h00A5);
        repeat (4) begin
            sd_clk_en = 1'b1; @(negedge clk); sd_clk_en = 1'b0;
            chk(cmd_line && !inhibit_cmd, "R2 no frame from lower write", {cmd_line, inhibit_cmd}, 2'b10);
        end

        // R1 reserved bits, R4 known CRC: CMD0 arg 0 -> 0x4A
        wr(2'b10, 16'hC000, 32'h0);
        chk(rd_data == 16'h00A5, "R1 reserved bits read zero", rd_data, 16'h00A5);
        chk(model_crc(40'h4000000000) == 7'h4A, "R4 bench model CRC0", model_crc(40'h4000000000), 7'h4A);
        full_frame(6'd0, 32'h0, 0, "R4 CMD0 frame");
        pulse_dat_done();

        // R4 known vector CMD8 arg 0x1AA -> CRC 0x43
        wr(2'b11, 16'h0800, 32'h0000_01AA);
        begin
            logic [47:0] f;
            shift_bits(48, 2, f);
            chk(f[7:1] == 7'h43, "R4 CMD8 CRC7", f[7:1], 7'h43);
            chk(f == model_frame(6'd8, 32'h1AA), "R3 CMD8 frame", f, model_frame(6'd8, 32'h1AA));
        end
        @(negedge clk);

        // R3 random commands
        for (int k = 0; k < 24; k++) begin
            logic [5:0]  idx = 6'($urandom_range(63));
            logic [31:0] arg = $urandom();
            wr(2'b11, {2'b00, idx, 8'h00}, arg);
            chk(inhibit_cmd && !cmd_line, "R3 launch sets inhibit and start bit", {inhibit_cmd, cmd_line}, 2'b10);
            chk(rd_data == {2'b00, idx, 8'h00}, "R3 index stored", rd_data, {2'b00, idx, 8'h00});
            full_frame(idx, arg, 3, "R3 random frame");
        end

        // R6 relaunch mid-frame
        begin
            logic [47:0] f;
            int cut = int'($urandom_range(40, 5));
            wr(2'b11, 16'h1100, 32'hDEAD_BEEF);
            shift_bits(cut, 1, f);
            chk(cmd_done == 1'b0 && inhibit_cmd, "R6 first frame still busy", {cmd_done, inhibit_cmd}, 2'b01);
            wr(2'b11, 16'h2A00, 32'h1234_5678);
            full_frame(6'h2A, 32'h1234_5678, 1, "R6 relaunched frame");
        end

        // R7 DAT inhibit
        wr(2'b11, 16'h1120, 32'h0);
        chk(inhibit_dat && data_present, "R7 data launch inhibits DAT", {inhibit_dat, data_present}, 2'b11);
        full_frame(6'h11, 32'h0, 0, "R7 data cmd frame");
        chk(inhibit_dat, "R7 DAT inhibit held after CMD end", inhibit_dat, 1);
        pulse_dat_done();
        chk(!inhibit_dat, "R7 dat_done clears DAT inhibit", inhibit_dat, 0);

        // R8 abort with read active, then with write active
        rd_active = 1'b1;
        wr(2'b11, 16'h0CC0, 32'h0);
        rd_active = 1'b0;
        chk(stop_buf_read && !stop_dat_drive, "R8 abort during read", {stop_buf_read, stop_dat_drive}, 2'b10);
        full_frame(6'h0C, 32'h0, 0, "R8 abort frame");
        chk(stop_buf_read, "R8 stop held after frame", stop_buf_read, 1);
        wr_active = 1'b1;
        wr(2'b11, 16'h34C0, 32'h0);
        wr_active = 1'b0;
        chk(!stop_buf_read && stop_dat_drive, "R8 abort during write", {stop_buf_read, stop_dat_drive}, 2'b01);
        full_frame(6'h34, 32'h0, 0, "R8 abort write frame");
        wr(2'b11, 16'h0D00, 32'h0);
        chk(!stop_buf_read && !stop_dat_drive, "R8 normal launch clears stops", {stop_buf_read, stop_dat_drive}, 0);
        full_frame(6'h0D, 32'h0, 0, "R8 normal frame");

        // R9 suspend fail then success, with DAT inhibit held
        wr(2'b11, 16'h1220, 32'h0);
        full_frame(6'h12, 32'h0, 0, "R9 data cmd frame");
        wr(2'b11, 16'h3440, 32'h0);
        full_frame(6'h34, 32'h0, 0, "R9 suspend frame");
        susp_valid = 1'b1; susp_ok = 1'b0; @(negedge clk); susp_valid = 1'b0;
        chk(inhibit_dat && !bus_released, "R9 failed suspend keeps state", {inhibit_dat, bus_released}, 2'b10);
        wr(2'b11, 16'h3440, 32'h0);
        full_frame(6'h34, 32'h0, 0, "R9 suspend retry frame");
        susp_valid = 1'b1; susp_ok = 1'b1; @(negedge clk); susp_valid = 1'b0; susp_ok = 1'b0;
        chk(!inhibit_dat && bus_released, "R9 suspend success releases bus", {inhibit_dat, bus_released}, 2'b01);

        // R10 resume, then a normal launch clears it
        wr(2'b11, 16'h3480, 32'h0);
        chk(resume_busy_chk && !bus_released, "R10 resume sets busy check", {resume_busy_chk, bus_released}, 2'b10);
        full_frame(6'h34, 32'h0, 0, "R10 resume frame");
        chk(resume_busy_chk, "R10 resume level held", resume_busy_chk, 1);
        wr(2'b11, 16'h0100, 32'h0);
        chk(!resume_busy_chk, "R10 normal launch clears", resume_busy_chk, 0);
        full_frame(6'h01, 32'h0, 0, "R10 normal frame");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule